// File: doc/BRIEF.md
# Power-Fail Shutdown Sequencer

This block sits between two supply comparators and a processor that keeps its working data in battery-backed RAM. One comparator gives an early warning that the supply is sagging, and a second one trips at the lower level below which the processor can no longer run safely. The block turns these two levels into an ordered shutdown. It first raises a non-maskable interrupt request so that firmware can finish and save its critical data. It keeps that warning window open for a guaranteed minimum number of cycles. It then lets any RAM write that is already under way complete. Only after that does it block every RAM chip select and hold the processor in reset.

When the supply comes back, reset and the chip-select block stay in force for a programmable number of cycles before the processor is released. A short dip below the low threshold still produces a complete reset, so the processor never carries on in a confused state. If a write cycle never finishes, a timeout forces the reset anyway. The comparator levels come from another domain and pass through synchronizer flops. The write-activity flag and the chip-select decode outputs are synchronous to the block's clock. All pins are plain control levels; nothing here streams data, so no valid/ready handshake is used.

Top module: `pwr_shutdown_seq`

## Requirements
- R1: While `rst_n` is low and just after it rises, the sequencer is in the hold-off state: `seq_state`=4, `cpu_rst`=1, `nmi_req`=0 and `ram_cs`=0. It reaches the run state after `HOLD_CYC` cycles with a clean supply.
- R2: Each comparator input reaches the state machine through `SYNC_STAGES` flops. From run, either level being high moves the sequencer to the warning state. `nmi_req` is high exactly in the warning and drain states.
- R3: The sequencer stays in warning for at least `WARN_MIN` cycles. It moves on to drain only once the low-supply level has been seen, so an interrupt always comes before reset.
- R4: In drain the chip selects follow the decode inputs. The sequencer goes to reset on the first cycle in which `wr_busy` is low, so a write in progress is never cut short.
- R5: `ram_cs` is all zeros whenever `cpu_rst` is high. Otherwise it equals `cs_dec`.
- R6: Once the low-supply level has been seen during warning, the full sequence runs through drain into reset, even if the supply recovers first.
- R7: In reset the sequencer stays there while the low-supply level is high. It then holds reset for `HOLD_CYC` further cycles in hold-off. Low supply during hold-off returns it to reset, and the count restarts on the next exit.
- R8: If `wr_busy` stays high for `DRAIN_TMO` cycles in drain, the sequencer enters reset anyway.
- R9: `seq_state` reports the state as run=0, warning=1, drain=2, reset=3, hold-off=4.
- R10: A warning that clears before any low-supply level is seen returns the sequencer to run without asserting `cpu_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_lvl | input | 1 | Early-warning comparator level, high when the supply is below the warning threshold |
| low_lvl | input | 1 | Low-supply comparator level, high when the supply is below the reset threshold |
| wr_busy | input | 1 | High while the processor has a RAM write cycle active |
| cs_dec | input | N_CS | Chip-select requests from the processor's address decode, active high |
| ram_cs | output | N_CS | Gated chip selects to the RAM, active high |
| nmi_req | output | 1 | Non-maskable interrupt request |
| cpu_rst | output | 1 | Processor reset, active high |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The bench drives a one-cycle low-supply pulse inside a warning. A design that treated this as noise would skip the reset and leave the processor running. It ends a write a few cycles after drain starts and checks that reset rises only after that. A design that gated on entry would show `ram_cs` dropping mid-write. It also holds the write forever to check that the timeout fires instead of hanging in drain. It brings low supply back during hold-off, where a design that kept counting would release reset too early. Finally it sends a warning with no low-supply level, where a design that always committed to shutdown would reset needlessly.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_WARN    = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_RESET   = 3'd3,
    ST_HOLDOFF = 3'd4
  } pseq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int WARN_MIN  = 8,
  parameter int DRAIN_TMO = 16,
  parameter int HOLD_CYC  = 20,
  parameter int CW        = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        warn_s,
  input  logic        low_s,
  input  logic        wr_busy,
  output pseq_state_e state_q
);

  localparam logic [CW-1:0] WARN_LAST  = CW'(WARN_MIN - 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_TMO - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  pseq_state_e   st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          seen_q, seen_nx;
  logic          low_any;

  assign low_any = seen_q | low_s;

  always_comb begin
    st_nx   = state_q;
    cnt_nx  = cnt_q;
    seen_nx = seen_q;
    case (state_q)
      ST_RUN: begin
        if (warn_s || low_s) begin
          st_nx   = ST_WARN;
          cnt_nx  = '0;
          seen_nx = low_s;
        end
      end
      ST_WARN: begin
        seen_nx = low_any;
        if (low_any && cnt_q == WARN_LAST) begin
          st_nx   = ST_DRAIN;
          cnt_nx  = '0;
          seen_nx = 1'b0;
        end else if (!warn_s && !low_any) begin
          st_nx = ST_RUN;
        end else if (cnt_q != WARN_LAST) begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!wr_busy || cnt_q == DRAIN_LAST) begin
          st_nx  = ST_RESET;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      ST_RESET: begin
        if (!low_s) begin
          st_nx  = ST_HOLDOFF;
          cnt_nx = '0;
        end
      end
      ST_HOLDOFF: begin
        if (low_s) begin
          st_nx  = ST_RESET;
          cnt_nx = '0;
        end else if (cnt_q == HOLD_LAST) begin
          st_nx  = ST_RUN;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      default: begin
        st_nx  = ST_RESET;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLDOFF;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= st_nx;
      cnt_q   <= cnt_nx;
      seen_q  <= seen_nx;
    end
  end

endmodule

// File: rtl/pwrseq_gate.sv
module pwrseq_gate
  import pwrseq_pkg::*;
#(
  parameter int N_CS = 2
) (
  input  pseq_state_e     state_q,
  input  logic [N_CS-1:0] cs_dec,
  output logic [N_CS-1:0] ram_cs,
  output logic            nmi_req,
  output logic            cpu_rst
);

  logic clamp;

  always_comb begin
    clamp   = (state_q == ST_RESET) || (state_q == ST_HOLDOFF);
    nmi_req = (state_q == ST_WARN)  || (state_q == ST_DRAIN);
  end

  assign cpu_rst = clamp;

  generate
    for (genvar i = 0; i < N_CS; i++) begin : g_cs
      assign ram_cs[i] = cs_dec[i] & ~clamp;
    end
  endgenerate

endmodule

// File: rtl/pwr_shutdown_seq.sv
module pwr_shutdown_seq
  import pwrseq_pkg::*;
#(
  parameter int N_CS        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WARN_MIN    = 8,
  parameter int DRAIN_TMO   = 16,
  parameter int HOLD_CYC    = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            warn_lvl,
  input  logic            low_lvl,
  input  logic            wr_busy,
  input  logic [N_CS-1:0] cs_dec,
  output logic [N_CS-1:0] ram_cs,
  output logic            nmi_req,
  output logic            cpu_rst,
  output logic [2:0]      seq_state
);

  localparam int CNT_MAX = max3(WARN_MIN, DRAIN_TMO, HOLD_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [1:0]  lvl_s;
  logic        warn_s;
  logic        low_s;
  pseq_state_e state_q;

  pwrseq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({low_lvl, warn_lvl}),
    .q     (lvl_s)
  );

  assign warn_s = lvl_s[0];
  assign low_s  = lvl_s[1];

  pwrseq_fsm #(
    .WARN_MIN  (WARN_MIN),
    .DRAIN_TMO (DRAIN_TMO),
    .HOLD_CYC  (HOLD_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .warn_s  (warn_s),
    .low_s   (low_s),
    .wr_busy (wr_busy),
    .state_q (state_q)
  );

  pwrseq_gate #(.N_CS(N_CS)) u_gate (
    .state_q (state_q),
    .cs_dec  (cs_dec),
    .ram_cs  (ram_cs),
    .nmi_req (nmi_req),
    .cpu_rst (cpu_rst)
  );

  assign seq_state = state_q;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int N_CS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            low_s,
  input logic            wr_busy,
  input logic [N_CS-1:0] ram_cs,
  input logic            cpu_rst,
  input logic [2:0]      seq_state
);

  AST_CS_BLOCKED_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> ram_cs == '0); // R5

  AST_RESET_ONLY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd3 && $past(seq_state) != 3'd3 && $past(seq_state) != 3'd4)
      |-> $past(seq_state) == 3'd2); // R3

  AST_DRAIN_IDLE_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd2 && !wr_busy) |=> seq_state == 3'd3); // R4

  AST_DRAIN_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 3'd2 |=> (seq_state == 3'd2 || seq_state == 3'd3)); // R6

  AST_HOLDOFF_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && low_s) |=> seq_state == 3'd3); // R7

endmodule

bind pwr_shutdown_seq pwrseq_chk #(.N_CS(N_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .low_s     (low_s),
  .wr_busy   (wr_busy),
  .ram_cs    (ram_cs),
  .cpu_rst   (cpu_rst),
  .seq_state (seq_state)
);

// File: tb/pwr_shutdown_seq_test.sv
`timescale 1ns/1ps
module pwr_shutdown_seq_test;

  localparam int N_CS      = 2;
  localparam int WARN_MIN  = 8;
  localparam int DRAIN_TMO = 16;
  localparam int HOLD_CYC  = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            warn_lvl = 1'b0;
  logic            low_lvl = 1'b0;
  logic            wr_busy = 1'b0;
  logic [N_CS-1:0] cs_dec = '0;
  logic [N_CS-1:0] ram_cs;
  logic            nmi_req;
  logic            cpu_rst;
  logic [2:0]      seq_state;

  always #10 clk = ~clk;

  pwr_shutdown_seq #(
    .N_CS(N_CS), .SYNC_STAGES(2), .WARN_MIN(WARN_MIN),
    .DRAIN_TMO(DRAIN_TMO), .HOLD_CYC(HOLD_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .warn_lvl(warn_lvl), .low_lvl(low_lvl),
    .wr_busy(wr_busy), .cs_dec(cs_dec), .ram_cs(ram_cs),
    .nmi_req(nmi_req), .cpu_rst(cpu_rst), .seq_state(seq_state)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: synchronizer pipes as queues, state as an integer
  int    m_state = 4;
  int    m_cnt   = 0;
  bit    m_seen  = 0;
  bit    wq[$];
  bit    lq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 4; m_cnt = 0; m_seen = 0;
      wq = '{0, 0}; lq = '{0, 0};
    end else begin
      bit w, l;
      w = wq[0]; l = lq[0];
      case (m_state)
        0: if (w || l) begin m_state = 1; m_cnt = 0; m_seen = l; end
        1: begin
          if ((m_seen || l) && m_cnt >= WARN_MIN - 1) begin
            m_state = 2; m_cnt = 0; m_seen = 0;
          end else if (!w && !l && !m_seen) begin
            m_state = 0;
          end else begin
            m_seen = m_seen || l;
            if (m_cnt < WARN_MIN - 1) m_cnt++;
          end
        end
        2: if (!wr_busy || m_cnt == DRAIN_TMO - 1) begin m_state = 3; m_cnt = 0; end
           else m_cnt++;
        3: if (!l) begin m_state = 4; m_cnt = 0; end
        default: begin
          if (l) begin m_state = 3; m_cnt = 0; end
          else if (m_cnt == HOLD_CYC - 1) begin m_state = 0; m_cnt = 0; end
          else m_cnt++;
        end
      endcase
      void'(wq.pop_front()); wq.push_back(warn_lvl);
      void'(lq.pop_front()); lq.push_back(low_lvl);
    end
  end

  // Per-cycle comparison plus event monitors
  int cyc = 0;
  int t_nmi_rise = -1, t_rst_rise = -1, n_rst_rise = 0;
  bit wr_at_rst = 0;
  bit p_nmi = 0, p_rst = 0;

  always @(posedge clk) begin
    bit e_rst, e_nmi;
    #5;
    cyc++;
    e_rst = (m_state == 3 || m_state == 4);
    e_nmi = (m_state == 1 || m_state == 2);
    check(int'(seq_state) == m_state, "R9 state code", seq_state, m_state);
    check(nmi_req == e_nmi, "R2 nmi_req", nmi_req, e_nmi);
    check(cpu_rst == e_rst, "R7 cpu_rst", cpu_rst, e_rst);
    check(ram_cs == (e_rst ? '0 : cs_dec), "R5 ram_cs", ram_cs, e_rst ? 0 : cs_dec);
    if (nmi_req && !p_nmi) t_nmi_rise = cyc;
    if (cpu_rst && !p_rst) begin t_rst_rise = cyc; n_rst_rise++; wr_at_rst = wr_busy; end
    p_nmi = nmi_req; p_rst = cpu_rst;
  end

  task automatic wait_state(input int s, input int lim, input string tag);
    int k = 0;
    while (int'(seq_state) != s && k < lim) begin @(negedge clk); k++; end
    check(int'(seq_state) == s, tag, seq_state, s);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int c0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(seq_state == 3'd4, "R1 state in reset", seq_state, 4);
    check(cpu_rst == 1'b1, "R1 cpu_rst in reset", cpu_rst, 1);
    check(nmi_req == 1'b0, "R1 nmi in reset", nmi_req, 0);
    rst_n = 1'b1;
    cs_dec = 2'b11;
    c0 = cyc;
    @(negedge clk);
    check(ram_cs == '0, "R1 ram_cs blocked after reset", ram_cs, 0);
    wait_state(0, 100, "R1 reaches run");
    check(cyc - c0 >= HOLD_CYC, "R1 hold-off length", cyc - c0, HOLD_CYC);

    // R5/R2: decode patterns pass in run
    for (int p = 0; p < 4; p++) begin
      cs_dec = 2'(p);
      @(negedge clk);
      check(ram_cs == 2'(p), "R5 pass-through in run", ram_cs, p);
    end

    // R10: warning alone returns to run
    r0 = n_rst_rise;
    warn_lvl = 1'b1;
    repeat (5) @(negedge clk);
    warn_lvl = 1'b0;
    repeat (15) @(negedge clk);
    check(seq_state == 3'd0, "R10 back to run", seq_state, 0);
    check(n_rst_rise == r0, "R10 no reset pulse", n_rst_rise - r0, 0);

    // R3/R4: full shutdown with a write in flight
    cs_dec = 2'b01;
    warn_lvl = 1'b1;
    repeat (3) @(negedge clk);
    low_lvl = 1'b1;
    wr_busy = 1'b1;
    wait_state(2, 60, "R3 enters drain");
    check(ram_cs == 2'b01, "R4 cs kept during write", ram_cs, 1);
    repeat (3) @(negedge clk);
    check(seq_state == 3'd2, "R4 still draining", seq_state, 2);
    check(ram_cs == 2'b01, "R4 cs still live", ram_cs, 1);
    wr_busy = 1'b0;
    wait_state(3, 10, "R4 reset after write");
    check(wr_at_rst == 1'b0, "R4 write done at reset", wr_at_rst, 0);
    check(t_rst_rise - t_nmi_rise >= WARN_MIN, "R3 warning window",
          t_rst_rise - t_nmi_rise, WARN_MIN);

    // R7: low returns during hold-off
    low_lvl = 1'b0; warn_lvl = 1'b0;
    wait_state(4, 10, "R7 enters hold-off");
    repeat (5) @(negedge clk);
    low_lvl = 1'b1;
    repeat (4) @(negedge clk);
    check(seq_state == 3'd3, "R7 back to reset", seq_state, 3);
    low_lvl = 1'b0;
    wait_state(4, 10, "R7 hold-off again");
    c0 = cyc;
    wait_state(0, 60, "R7 run after hold-off");
    check(cyc - c0 >= HOLD_CYC - 1, "R7 full hold restart", cyc - c0, HOLD_CYC);

    // R6: one-cycle dip still resets
    r0 = n_rst_rise;
    warn_lvl = 1'b1;
    @(negedge clk);
    low_lvl = 1'b1;
    @(negedge clk);
    low_lvl = 1'b0;
    repeat (2) @(negedge clk);
    warn_lvl = 1'b0;
    wait_state(3, 40, "R6 dip reaches reset");
    check(n_rst_rise == r0 + 1, "R6 reset pulse count", n_rst_rise - r0, 1);
    wait_state(0, 60, "R6 recovers to run");

    // R8: write that never ends
    cs_dec = 2'b10;
    wr_busy = 1'b1;
    warn_lvl = 1'b1; low_lvl = 1'b1;
    wait_state(2, 40, "R8 enters drain");
    c0 = cyc;
    wait_state(3, 40, "R8 timeout reset");
    check(wr_at_rst == 1'b1, "R8 forced with write busy", wr_at_rst, 1);
    check(cyc - c0 >= DRAIN_TMO - 1, "R8 drain length", cyc - c0, DRAIN_TMO);
    check(ram_cs == '0, "R5 cs blocked in reset", ram_cs, 0);
    wr_busy = 1'b0; warn_lvl = 1'b0; low_lvl = 1'b0;
    wait_state(0, 60, "R8 recovers to run");

    // R2: low level alone starts with warning
    low_lvl = 1'b1;
    repeat (3) @(negedge clk);
    check(seq_state == 3'd1, "R2 low alone warns first", seq_state, 1);
    check(nmi_req == 1'b1, "R2 nmi raised", nmi_req, 1);
    low_lvl = 1'b0;
    wait_state(0, 80, "R6 full cycle then run");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule